// File: doc/BRIEF.md
# Serial ADC Output Shifter

This block is the device-side serial read-out of a 14-bit converter, written as a synthesizable peripheral model. A conversion source supplies a parallel unsigned result and two extra sub-bits. The block watches an active-low chip select and a serial clock from a bus master. It produces the data-out bit stream that the master reads on rising clock edges in SPI mode 0 (clock idle low, data sampled on the rising edge).

A frame starts when chip select falls. The result and the sub-bits are captured at that instant. The stream is eight zero bits, then the 14 result bits most significant first, then the first sub-bit and the second sub-bit, and after that zeros for as long as chip select stays low. Raising chip select ends the frame at any point, and the next falling edge starts again from the first leading zero.

Both pins are sampled by the system clock through a synchronizer, so they must be slow next to that clock. The block drives a data value and a separate output enable. A pad or a wrapper turns these into the tri-state line, so the block needs no internal tri-state driver.

Top module: `adc_serial_out`

## Requirements
- R1: While chip select is high (deselected), `dout_oe` is 0 and `dout` is 0. After reset both are 0.
- R2: After chip select falls, `dout_oe` is 1. The first bit presented, before any serial clock edge, and the next seven bits are all 0.
- R3: Frame bits 8 to 21, counting from 0, are the result, most significant bit first: frame bit 8 is `result[13]` and frame bit 21 is `result[0]`.
- R4: Frame bit 22 is `sub_bits[1]` and frame bit 23 is `sub_bits[0]`.
- R5: From frame bit 24 onward, every further falling serial clock edge presents 0 for as long as chip select stays low.
- R6: `dout` moves to the next frame bit only after a falling serial clock edge. It holds its value through the rest of the low phase and through the whole high phase.
- R7: Chip select rising mid-frame ends the frame at once and drops `dout_oe`. The next chip select fall restarts at frame bit 0.
- R8: The result and the sub-bits are captured when chip select falls. Changing the inputs later in the frame does not alter the bits shifted out.
- R9: The coding is straight unsigned binary. An all-zeros result and an all-ones result are both shifted out bit for bit, unchanged.
- R10: Serial clock edges while chip select is high are ignored. The next frame still begins at frame bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the bus master |
| sclk | input | 1 | Serial clock from the bus master, idle low |
| result | input | 14 | Unsigned conversion result |
| sub_bits | input | 2 | Sub-bits sent after the result, bit 1 first |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the data pad, 1 while selected |

## Verification
The bench reads whole frames and checks the boundaries between the leading zeros, the result, the sub-bits and the zero tail. A design with an off-by-one counter would shift the result by one place or drop S0. It also clocks past bit 24; a counter that wraps instead of saturating would replay the frame there. Chip select is raised mid-frame and after serial clocks sent while deselected, to catch a design that resumes a stale position instead of restarting at the first zero. The result inputs are changed mid-frame to catch a design that reads them live. The bench samples each bit at the end of the low phase and again in the high phase, to catch output that moves on rising edges.

// File: rtl/adc_shift_pkg.sv
// Package: shared defaults and the pin event type for the serial ADC
// output shifter. Assumes nothing beyond a single system clock domain.
package adc_shift_pkg;

    localparam int DEF_LEAD_ZEROS  = 8;
    localparam int DEF_RESULT_BITS = 14;
    localparam int DEF_SUB_BITS    = 2;
    localparam int DEF_SYNC_STAGES = 2;

    // Sampled view of one external pin: settled level and one-cycle edge pulses.
    typedef struct packed {
        logic level;
        logic fell;
        logic rose;
    } pin_evt_t;

endpackage

// File: rtl/adc_shift_pin_sync.sv
// Module: adc_shift_pin_sync
// Brings one asynchronous pin into the clk domain and reports its settled
// level plus one-cycle pulses on falling and rising transitions.
// Assumes the pin stays at each level for several clk cycles.
module adc_shift_pin_sync
    import adc_shift_pkg::*;
#(
    parameter int   STAGES      = DEF_SYNC_STAGES,
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    output pin_evt_t evt
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer chain; the parameter selects a single flop or a shift chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RESET_LEVEL;
                else        chain_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_LEVEL}};
                else        chain_q <= {chain_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    // Remember the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RESET_LEVEL;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Decode the level and edge pulses.
    always_comb begin
        evt.level = chain_q[STAGES-1];
        evt.fell  = prev_q & ~chain_q[STAGES-1];
        evt.rose  = ~prev_q & chain_q[STAGES-1];
    end

endmodule

// File: rtl/adc_shift_position.sv
// Module: adc_shift_position
// Tracks the current bit position inside a frame. A restart or clear sends
// it to 0, and an advance steps it up to FRAME_BITS, where it saturates.
// Assumes restart, clear and advance are one-cycle pulses.
module adc_shift_position #(
    parameter int FRAME_BITS = 24,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_BITS);

    // Next position: restart and clear win, advance saturates at LIMIT.
    always_comb begin
        cnt_next = cnt_q;
        if (restart || clear)
            cnt_next = '0;
        else if (advance && (cnt_q != LIMIT))
            cnt_next = cnt_q + 1'b1;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    // R5: the position never passes the end of the frame.
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R5: once at the end, the position stays there until the frame ends.
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LIMIT && !restart && !clear) |=> (cnt_q == LIMIT));

endmodule

// File: rtl/adc_shift_frame.sv
// Module: adc_shift_frame
// Holds the word captured at frame start and drives the serial data bit
// for the frame position. Positions below LEAD_ZEROS and from the frame
// end onward give 0. Assumes cnt_next comes from adc_shift_position.
module adc_shift_frame #(
    parameter int LEAD_ZEROS  = 8,
    parameter int RESULT_BITS = 14,
    parameter int SUB_BITS    = 2,
    parameter int CNT_W       = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic                   clear,
    input  logic                   advance,
    input  logic [RESULT_BITS-1:0] result,
    input  logic [SUB_BITS-1:0]    sub_bits,
    input  logic [CNT_W-1:0]       cnt_next,
    output logic                   dout
);

    localparam int DATA_W = RESULT_BITS + SUB_BITS;
    localparam int TOTAL  = LEAD_ZEROS + DATA_W;

    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] fresh_word;
    logic              dout_q;

    // Picks the frame bit at a position; outside the data window it is 0.
    function automatic logic pick_bit(input logic [DATA_W-1:0] w,
                                      input logic [CNT_W-1:0]  pos);
        logic b;
        b = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            if (int'(pos) == LEAD_ZEROS + k) b = w[DATA_W-1-k];
        end
        return b;
    endfunction

    // Concatenate result and sub-bits into the word sent MSB first.
    always_comb fresh_word = {result, sub_bits};

    // Capture the word once per frame, at the chip select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (restart) word_q <= fresh_word;
    end

    // Output bit register: present bit 0 at start and step on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= 1'b0;
        else if (restart) dout_q <= pick_bit(fresh_word, cnt_next);
        else if (clear)   dout_q <= 1'b0;
        else if (advance) dout_q <= pick_bit(word_q, cnt_next);
    end

    always_comb dout = dout_q;

    // R6: without an event the data bit does not move.
    p_dout_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !clear && !advance) |=> $stable(dout_q));

    // R8: the captured word changes only at a frame start.
    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(word_q));

    // Frame sizing sanity at elaboration.
    initial begin
        p_frame_fits: assert (TOTAL < (1 << CNT_W));
    end

endmodule

// File: rtl/adc_serial_out.sv
// Module: adc_serial_out (top)
// Device-side serial output of a converter result. Chip select falling
// starts a frame: LEAD_ZEROS zeros, the result MSB first, the sub-bits,
// then zeros. Chip select high ends it. Each falling serial clock edge
// moves to the next bit. Assumes cs_n and sclk are slow next to clk.
module adc_serial_out
    import adc_shift_pkg::*;
#(
    parameter int LEAD_ZEROS  = DEF_LEAD_ZEROS,
    parameter int RESULT_BITS = DEF_RESULT_BITS,
    parameter int SUB_BITS    = DEF_SUB_BITS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic [RESULT_BITS-1:0] result,
    input  logic [SUB_BITS-1:0]    sub_bits,
    output logic                   dout,
    output logic                   dout_oe
);

    localparam int FRAME_BITS = LEAD_ZEROS + RESULT_BITS + SUB_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    pin_evt_t         cs_evt;
    pin_evt_t         sck_evt;
    logic             restart;
    logic             clear;
    logic             advance;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             oe_q;

    adc_shift_pin_sync #(.STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_cs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cs_n),
        .evt   (cs_evt)
    );

    adc_shift_pin_sync #(.STAGES(SYNC_STAGES), .RESET_LEVEL(1'b0)) u_sck_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sclk),
        .evt   (sck_evt)
    );

    // Frame events: start, abort, and a step only while selected.
    always_comb begin
        restart = cs_evt.fell;
        clear   = cs_evt.rose;
        advance = sck_evt.fell & ~cs_evt.level & ~cs_evt.fell;
    end

    adc_shift_position #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .clear    (clear),
        .advance  (advance),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next)
    );

    adc_shift_frame #(
        .LEAD_ZEROS  (LEAD_ZEROS),
        .RESULT_BITS (RESULT_BITS),
        .SUB_BITS    (SUB_BITS),
        .CNT_W       (CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .clear    (clear),
        .advance  (advance),
        .result   (result),
        .sub_bits (sub_bits),
        .cnt_next (cnt_next),
        .dout     (dout)
    );

    // Output enable: set at frame start, dropped when chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (restart) oe_q <= 1'b1;
        else if (clear)   oe_q <= 1'b0;
    end

    always_comb dout_oe = oe_q;

    // R1: a deselected device does not drive the line.
    p_oe_off_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_evt.level |=> !dout_oe);

    // R1: the data value rests at 0 while the enable is off.
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R7 / R2: every frame start goes back to the first leading zero.
    p_restart_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (dout_oe && cnt_q == '0 && (LEAD_ZEROS == 0 || !dout)));

    // R5: at the end of the frame the line carries zeros.
    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(FRAME_BITS)) |-> !dout);

endmodule

// File: tb/adc_serial_out_test.sv
// Directed bench for adc_serial_out: each task drives one scenario and
// checks its own results at the ports.
module adc_serial_out_test;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [13:0] result = '0;
    logic [1:0]  sub_bits = '0;
    logic        dout;
    logic        dout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_serial_out uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .result   (result),
        .sub_bits (sub_bits),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected frame bit i from the requirements (R2..R5).
    function automatic logic exp_bit(input int i, input logic [13:0] r, input logic [1:0] s);
        if (i < 8)  return 1'b0;
        if (i < 22) return r[13-(i-8)];
        if (i < 24) return s[1-(i-22)];
        return 1'b0;
    endfunction

    function automatic string req_of(input int i);
        if (i < 8)  return "R2";
        if (i < 22) return "R3";
        if (i < 24) return "R4";
        return "R5";
    endfunction

    task automatic select();
        cs_n = 1'b0;
        wait_clk(HALF);
        check("R2", dout_oe, 1'b1, "oe after select");
        check("R2", dout, 1'b0, "first bit before any sclk");
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        wait_clk(HALF);
        check("R1", dout_oe, 1'b0, "oe after deselect");
        check("R1", dout, 1'b0, "dout after deselect");
    endtask

    // Clock n bits from frame position first; R6 compares low and high phase.
    task automatic read_bits(input int first, input int n, input logic [13:0] r, input logic [1:0] s);
        for (int i = first; i < first + n; i++) begin
            logic lo_val;
            lo_val = dout;
            sclk = 1'b1;
            wait_clk(HALF);
            check(req_of(i), dout, exp_bit(i, r, s), $sformatf("frame bit %0d", i));
            check("R6", dout, lo_val, $sformatf("bit %0d held across rising edge", i));
            sclk = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic t_reset();
        check("R1", dout_oe, 1'b0, "oe after reset");
        check("R1", dout, 1'b0, "dout after reset");
    endtask

    task automatic t_full_frame(input logic [13:0] r, input logic [1:0] s);
        result = r; sub_bits = s;
        select();
        read_bits(0, 24, r, s);
        read_bits(24, 6, r, s);   // R5 zero tail
        deselect();
    endtask

    task automatic t_capture();
        logic [13:0] r; logic [1:0] s;
        r = 14'h1B3D; s = 2'b01;
        result = r; sub_bits = s;
        select();
        result = ~r; sub_bits = ~s;  // R8: late change must not leak
        read_bits(0, 24, r, s);
        deselect();
    endtask

    task automatic t_abort();
        logic [13:0] r; logic [1:0] s;
        r = 14'h3FF0; s = 2'b11;
        result = r; sub_bits = s;
        select();
        read_bits(0, 12, r, s);
        cs_n = 1'b1;
        wait_clk(HALF);
        check("R7", dout_oe, 1'b0, "oe after mid-frame abort");
        r = 14'h0C0F; s = 2'b10;
        result = r; sub_bits = s;
        select();
        read_bits(0, 24, r, s);  // R7 restart from first zero
        deselect();
    endtask

    task automatic t_ignore_deselected();
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; wait_clk(HALF);
            check("R10", dout_oe, 1'b0, "oe with sclk while deselected");
            check("R10", dout, 1'b0, "dout with sclk while deselected");
            sclk = 1'b0; wait_clk(HALF);
        end
        t_full_frame(14'h2A5C, 2'b10);  // R10: still starts at bit 0
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_full_frame(14'h2A5C, 2'b10);
        t_full_frame(14'h0000, 2'b00);  // R9 zero scale
        t_full_frame(14'h3FFF, 2'b11);  // R9 full scale
        t_capture();
        t_abort();
        t_ignore_deselected();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule